// File: doc/BRIEF.md
# Interrupt Status and Summary Register

This block holds the 32-bit event status word of a network controller's host interface. The transmit and receive engines, the general-purpose timer and the bus logic report events as single-cycle pulses. Each pulse sets a sticky bit in the status word. The host clears those bits by writing ones to them. A write of zero to a bit leaves that bit unchanged.

Two summary bits are recomputed on every clock from the stored event bits:
- The normal summary covers routine completions.
- The abnormal summary covers stall and error conditions.

A level interrupt output is high whenever either summary is set. The read value also carries two 3-bit process-state fields. These fields are taken live from the transmit and receive run controls and are not stored.

Top module: `irq_status_reg`

## Requirements
- R1: After reset, every bit of `rdData` reads 0 and `irqOut` is low.
- R2: Each event pulse sets its bit on the next clock, and the bit stays set until the host clears it. The bit positions are:
  - transmit stopped: bit 1
  - transmit buffer unavailable: bit 2
  - transmit jabber: bit 3
  - transmit underflow: bit 5
  - receive done: bit 6
  - receive buffer unavailable: bit 7
  - receive stopped: bit 8
  - receive watchdog: bit 9
  - timer expired: bit 11
  - fatal bus error: bit 13
- R3: A transmit-done pulse sets bit 0 only when `txIocFlag` is 1 in the same cycle. When `txIocFlag` is 0 the pulse has no effect.
- R4: A host write (`wrEn`=1) clears, on the next clock, every event bit whose `wrData` bit is 1. Event bits whose `wrData` bit is 0 keep their value.
- R5: If an event pulse and a write-one-to-clear hit the same bit in one cycle, the bit ends up set.
- R6: Bit 16 (normal summary) is 1 exactly when at least one of bits 0, 2 or 6 is set.
- R7: Bit 15 (abnormal summary) is 1 exactly when at least one of bits 1, 3, 5, 7, 8, 9, 11 or 13 is set.
- R8: When all source bits of a summary are cleared, that summary reads 0 in the same cycle as its sources.
- R9: `irqOut` is 1 exactly when bit 15 or bit 16 is 1.
- R10: Bits 22:20 read 3 when `txRun` is 1 and 0 otherwise. Bits 19:17 read 3 when `rxRun` is 1 and 0 otherwise. Both fields follow the controls without delay.
- R11: Host writes to bits 15 and 16, to bits 17 to 22, and to the unused positions (4, 10, 12, 14, 23 to 31) have no effect. The unused positions always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| txDoneStb | input | 1 | Transmit descriptor completed |
| txIocFlag | input | 1 | Completed descriptor requested an interrupt |
| txStopStb | input | 1 | Transmit process stopped |
| txBufUnavStb | input | 1 | Transmit buffer unavailable |
| txJabberStb | input | 1 | Transmit jabber timeout |
| txUnderflowStb | input | 1 | Transmit underflow |
| rxDoneStb | input | 1 | Frame received |
| rxBufUnavStb | input | 1 | Receive buffer unavailable |
| rxStopStb | input | 1 | Receive process stopped |
| rxWdogStb | input | 1 | Receive watchdog timeout |
| gpTimerStb | input | 1 | General-purpose timer expired |
| busErrStb | input | 1 | Fatal bus error |
| txRun | input | 1 | Transmit start control |
| rxRun | input | 1 | Receive start control |
| wrEn | input | 1 | Host write strobe for the status word |
| wrData | input | 32 | Host write data, where a 1 clears that bit |
| rdData | output | 32 | Status word read value |
| irqOut | output | 1 | Level interrupt request |

## Verification
The assertions assume that every event input is a synchronous strobe sampled on the rising edge. They also assume that `wrEn` qualifies `wrData` in the same cycle, and that the run controls are stable levels. The bench drives all inputs on the falling edge and holds each strobe for exactly one cycle. It samples the outputs on the next falling edge, one register stage after the stimulus. Simultaneous set and clear is produced on purpose, so the set-over-clear priority is exercised against the assertions rather than avoided.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;
  localparam int STATUS_W = 32;

  localparam int TX_DONE_BIT   = 0;
  localparam int TX_STOP_BIT   = 1;
  localparam int TX_UNAV_BIT   = 2;
  localparam int TX_JAB_BIT    = 3;
  localparam int TX_UNF_BIT    = 5;
  localparam int RX_DONE_BIT   = 6;
  localparam int RX_UNAV_BIT   = 7;
  localparam int RX_STOP_BIT   = 8;
  localparam int RX_WDOG_BIT   = 9;
  localparam int GP_TIMER_BIT  = 11;
  localparam int BUS_ERR_BIT   = 13;
  localparam int ABN_SUM_BIT   = 15;
  localparam int NRM_SUM_BIT   = 16;

  localparam logic [STATUS_W-1:0] NORMAL_MASK =
    (STATUS_W'(1) << TX_DONE_BIT) | (STATUS_W'(1) << TX_UNAV_BIT) |
    (STATUS_W'(1) << RX_DONE_BIT);

  localparam logic [STATUS_W-1:0] ABNORMAL_MASK =
    (STATUS_W'(1) << TX_STOP_BIT) | (STATUS_W'(1) << TX_JAB_BIT) |
    (STATUS_W'(1) << TX_UNF_BIT)  | (STATUS_W'(1) << RX_UNAV_BIT) |
    (STATUS_W'(1) << RX_STOP_BIT) | (STATUS_W'(1) << RX_WDOG_BIT) |
    (STATUS_W'(1) << GP_TIMER_BIT) | (STATUS_W'(1) << BUS_ERR_BIT);

  localparam logic [STATUS_W-1:0] EVENT_MASK = NORMAL_MASK | ABNORMAL_MASK;

  typedef struct packed {
    logic [STATUS_W-1:0] setMask;
    logic [STATUS_W-1:0] clrMask;
  } statusStrobes_t;
endpackage

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_status_pkg::*;
(
  input  logic                txDoneStb,
  input  logic                txIocFlag,
  input  logic                txStopStb,
  input  logic                txBufUnavStb,
  input  logic                txJabberStb,
  input  logic                txUnderflowStb,
  input  logic                rxDoneStb,
  input  logic                rxBufUnavStb,
  input  logic                rxStopStb,
  input  logic                rxWdogStb,
  input  logic                gpTimerStb,
  input  logic                busErrStb,
  input  logic                wrEn,
  input  logic [STATUS_W-1:0] wrData,
  output statusStrobes_t      strobes
);
  always_comb begin
    strobes.setMask = '0;
    strobes.setMask[TX_DONE_BIT]  = txDoneStb & txIocFlag;
    strobes.setMask[TX_STOP_BIT]  = txStopStb;
    strobes.setMask[TX_UNAV_BIT]  = txBufUnavStb;
    strobes.setMask[TX_JAB_BIT]   = txJabberStb;
    strobes.setMask[TX_UNF_BIT]   = txUnderflowStb;
    strobes.setMask[RX_DONE_BIT]  = rxDoneStb;
    strobes.setMask[RX_UNAV_BIT]  = rxBufUnavStb;
    strobes.setMask[RX_STOP_BIT]  = rxStopStb;
    strobes.setMask[RX_WDOG_BIT]  = rxWdogStb;
    strobes.setMask[GP_TIMER_BIT] = gpTimerStb;
    strobes.setMask[BUS_ERR_BIT]  = busErrStb;
    strobes.clrMask = wrEn ? (wrData & EVENT_MASK) : '0;
  end
endmodule

// File: rtl/irq_status_datapath.sv
module irq_status_datapath
  import irq_status_pkg::*;
#(
  parameter int STATE_W      = 3,
  parameter int RX_STATE_LSB = 17,
  parameter int TX_STATE_LSB = 20,
  parameter int RUN_CODE     = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  statusStrobes_t      strobes,
  input  logic                txRun,
  input  logic                rxRun,
  output logic [STATUS_W-1:0] rdData,
  output logic                irqOut
);
  localparam int NUM_PROC = 2;
  localparam logic [STATE_W-1:0] RUN_VAL = STATE_W'(RUN_CODE);

  logic [STATUS_W-1:0] evtQ;
  logic [STATUS_W-1:0] evtNext;
  logic                nrmQ;
  logic                abnQ;
  logic [NUM_PROC-1:0] runBits;
  logic [STATUS_W-1:0] fieldWord [NUM_PROC];

  // Set has priority over clear: the set mask is ORed in after clearing.
  assign evtNext = ((evtQ & ~strobes.clrMask) | strobes.setMask) & EVENT_MASK;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      evtQ <= '0;
      nrmQ <= 1'b0;
      abnQ <= 1'b0;
    end else begin
      evtQ <= evtNext;
      nrmQ <= |(evtNext & NORMAL_MASK);
      abnQ <= |(evtNext & ABNORMAL_MASK);
    end
  end

  assign runBits = {txRun, rxRun};

  for (genvar g = 0; g < NUM_PROC; g++) begin : g_proc
    localparam int LSB = (g == 0) ? RX_STATE_LSB : TX_STATE_LSB;
    assign fieldWord[g] = runBits[g] ? (STATUS_W'(RUN_VAL) << LSB) : '0;
  end

  always_comb begin
    rdData = evtQ;
    rdData[NRM_SUM_BIT] = nrmQ;
    rdData[ABN_SUM_BIT] = abnQ;
    rdData = rdData | fieldWord[0] | fieldWord[1];
  end

  assign irqOut = nrmQ | abnQ;
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg
  import irq_status_pkg::*;
#(
  parameter int STATE_W      = 3,
  parameter int RX_STATE_LSB = 17,
  parameter int TX_STATE_LSB = 20,
  parameter int RUN_CODE     = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                txDoneStb,
  input  logic                txIocFlag,
  input  logic                txStopStb,
  input  logic                txBufUnavStb,
  input  logic                txJabberStb,
  input  logic                txUnderflowStb,
  input  logic                rxDoneStb,
  input  logic                rxBufUnavStb,
  input  logic                rxStopStb,
  input  logic                rxWdogStb,
  input  logic                gpTimerStb,
  input  logic                busErrStb,
  input  logic                txRun,
  input  logic                rxRun,
  input  logic                wrEn,
  input  logic [STATUS_W-1:0] wrData,
  output logic [STATUS_W-1:0] rdData,
  output logic                irqOut
);
  statusStrobes_t strobes;

  irq_status_ctrl ctrl_i (
    .txDoneStb(txDoneStb), .txIocFlag(txIocFlag), .txStopStb(txStopStb),
    .txBufUnavStb(txBufUnavStb), .txJabberStb(txJabberStb),
    .txUnderflowStb(txUnderflowStb), .rxDoneStb(rxDoneStb),
    .rxBufUnavStb(rxBufUnavStb), .rxStopStb(rxStopStb),
    .rxWdogStb(rxWdogStb), .gpTimerStb(gpTimerStb), .busErrStb(busErrStb),
    .wrEn(wrEn), .wrData(wrData), .strobes(strobes)
  );

  irq_status_datapath #(
    .STATE_W(STATE_W), .RX_STATE_LSB(RX_STATE_LSB),
    .TX_STATE_LSB(TX_STATE_LSB), .RUN_CODE(RUN_CODE)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .txRun(txRun),
    .rxRun(rxRun), .rdData(rdData), .irqOut(irqOut)
  );
endmodule

// File: rtl/irq_status_chk.sv
module irq_status_chk
  import irq_status_pkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic                txDoneStb,
  input logic                txIocFlag,
  input logic                rxDoneStb,
  input logic                busErrStb,
  input logic                wrEn,
  input logic [STATUS_W-1:0] wrData,
  input logic [STATUS_W-1:0] rdData,
  input logic                irqOut
);
  localparam logic [STATUS_W-1:0] UNUSED_MASK =
    ~(EVENT_MASK | (STATUS_W'(1) << ABN_SUM_BIT) |
      (STATUS_W'(1) << NRM_SUM_BIT) | STATUS_W'(32'h007E_0000));

  a_r2_bus_err_sets: assert property (@(posedge clk) disable iff (!rstN)
    busErrStb |=> rdData[BUS_ERR_BIT]);

  a_r3_no_ioc_no_set: assert property (@(posedge clk) disable iff (!rstN)
    (txDoneStb && !txIocFlag && !wrEn) |=> rdData[TX_DONE_BIT] == $past(rdData[TX_DONE_BIT]));

  a_r4_clear_bus_err: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrData[BUS_ERR_BIT] && !busErrStb) |=> !rdData[BUS_ERR_BIT]);

  a_r5_set_beats_clear: assert property (@(posedge clk) disable iff (!rstN)
    rxDoneStb |=> rdData[RX_DONE_BIT]);

  a_r6_normal_summary: assert property (@(posedge clk) disable iff (!rstN)
    rdData[NRM_SUM_BIT] == (|(rdData & NORMAL_MASK)));

  a_r7_abnormal_summary: assert property (@(posedge clk) disable iff (!rstN)
    rdData[ABN_SUM_BIT] == (|(rdData & ABNORMAL_MASK)));

  a_r9_irq_level: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == (rdData[ABN_SUM_BIT] | rdData[NRM_SUM_BIT]));

  a_r11_unused_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rdData & UNUSED_MASK) == '0);
endmodule

bind irq_status_reg irq_status_chk chk_i (.*);

// File: tb/irq_status_reg_tb.sv
`timescale 1ns/1ps
module irq_status_reg_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic txDoneStb = 0, txIocFlag = 0, txStopStb = 0, txBufUnavStb = 0;
  logic txJabberStb = 0, txUnderflowStb = 0, rxDoneStb = 0, rxBufUnavStb = 0;
  logic rxStopStb = 0, rxWdogStb = 0, gpTimerStb = 0, busErrStb = 0;
  logic txRun = 0, rxRun = 0, wrEn = 0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic irqOut;
  int checks = 0;
  int errors = 0;

  localparam logic [31:0] NRM = 32'h0001_0000;
  localparam logic [31:0] ABN = 32'h0000_8000;
  localparam logic [31:0] NRM_SRC = 32'h0000_0045;

  always #2.5 clk = ~clk;

  irq_status_reg dut_i (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // One cycle of stimulus; outputs are sampled on the following falling edge.
  task automatic drive(logic [31:0] ev, logic ioc, logic we, logic [31:0] wd);
    @(negedge clk);
    txDoneStb = ev[0]; txStopStb = ev[1]; txBufUnavStb = ev[2];
    txJabberStb = ev[3]; txUnderflowStb = ev[5]; rxDoneStb = ev[6];
    rxBufUnavStb = ev[7]; rxStopStb = ev[8]; rxWdogStb = ev[9];
    gpTimerStb = ev[11]; busErrStb = ev[13];
    txIocFlag = ioc; wrEn = we; wrData = wd;
    @(negedge clk);
    {txDoneStb, txStopStb, txBufUnavStb, txJabberStb, txUnderflowStb} = '0;
    {rxDoneStb, rxBufUnavStb, rxStopStb, rxWdogStb, gpTimerStb, busErrStb} = '0;
    txIocFlag = 0; wrEn = 0; wrData = '0;
  endtask

  task automatic t_reset();
    check("R1 reset word", rdData, 32'h0);
    check("R1 reset irq", {31'b0, irqOut}, 32'h0);
  endtask

  task automatic t_each_event();
    int pos[11] = '{0, 1, 2, 3, 5, 6, 7, 8, 9, 11, 13};
    foreach (pos[i]) begin
      logic [31:0] bitv = 32'h1 << pos[i];
      logic [31:0] sumv = (bitv & NRM_SRC) != 0 ? NRM : ABN;
      drive(bitv, 1'b1, 1'b0, '0);
      check("R2/R6/R7 event sets bit and summary", rdData, bitv | sumv);
      check("R9 irq high", {31'b0, irqOut}, 32'h1);
      drive('0, 1'b0, 1'b1, bitv);
      check("R8 summary drops", rdData, 32'h0);
      check("R9 irq low", {31'b0, irqOut}, 32'h0);
    end
  endtask

  task automatic t_ioc();
    drive(32'h1, 1'b0, 1'b0, '0);
    check("R3 tx done without ioc", rdData, 32'h0);
    drive(32'h1, 1'b1, 1'b0, '0);
    check("R3 tx done with ioc", rdData, 32'h1 | NRM);
    drive('0, 1'b0, 1'b1, 32'h1);
  endtask

  task automatic t_partial_clear();
    drive(32'h0000_2044, 1'b0, 1'b0, '0);
    check("R6/R7 both summaries", rdData, 32'h0000_2044 | NRM | ABN);
    drive('0, 1'b0, 1'b1, 32'h0000_0040);
    check("R4 partial clear", rdData, 32'h0000_2004 | NRM | ABN);
    drive('0, 1'b0, 1'b1, 32'h0000_0004);
    check("R8 normal drops alone", rdData, 32'h0000_2000 | ABN);
    drive('0, 1'b0, 1'b1, 32'h0000_2000);
    check("R4 full clear", rdData, 32'h0);
  endtask

  task automatic t_set_wins();
    drive(32'h0000_0040, 1'b0, 1'b1, 32'h0000_0040);
    check("R5 set beats clear", rdData, 32'h0000_0040 | NRM);
    drive('0, 1'b0, 1'b1, 32'h0000_0040);
  endtask

  task automatic t_ignored_writes();
    drive(32'h0000_0002, 1'b0, 1'b0, '0);
    drive('0, 1'b0, 1'b1, 32'hFF7F_D000 & ~32'h0000_2000);
    check("R11 writes to summaries/fields/unused ignored", rdData, 32'h0000_0002 | ABN);
    check("R11 irq unchanged", {31'b0, irqOut}, 32'h1);
    drive('0, 1'b0, 1'b1, 32'h0000_0002);
  endtask

  task automatic t_proc_fields();
    @(negedge clk); txRun = 1; #1;
    check("R10 tx field running", rdData, 32'h0030_0000);
    rxRun = 1; #1;
    check("R10 both fields running", rdData, 32'h0036_0000);
    txRun = 0; #1;
    check("R10 rx field only", rdData, 32'h0006_0000);
    rxRun = 0; #1;
    check("R10 fields idle", rdData, 32'h0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_each_event();
    t_ioc();
    t_partial_clear();
    t_set_wins();
    t_ignored_writes();
    t_proc_fields();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule